// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the fetch address for a 32-bit RISC pipeline that has sixteen general registers. Every cycle it looks at the opcode of the instruction in the execute stage. For a branch, it decides whether the branch is taken, using register operands that have already been read, and captures the target address from a register. It then lets exactly one following instruction go through the slot position before it loads the target into the fetch address. Outside of branches, the address advances by one instruction word on each cycle that is not stalled.

A mode input picks how the slot is treated. In exposed-slot mode, the instruction after a branch is part of the architecture: it executes whether the branch is taken or not, and the compiler fills it. In hardware-hold mode, a taken branch raises suspend signals for the ALU stage and the register-write stage for the slot cycle, so the wrong-path instruction changes no state. Memory, the register file and the ALU live outside this block.

Top module: `dbr_pc_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, pc_o is 0, and redirect_o, alu_susp_o and wb_susp_o are 0.
- R2: On a cycle with stall_i low and no redirect load, pc_o increases by 1 (one instruction word) at the next rising edge.
- R3: On a cycle with stall_i high, pc_o holds its value, and a pending redirect stays pending with its target unchanged.
- R4: Opcode 19 on op_i (the top byte of the instruction word, bits 31:24) is branch-on-true. It is taken only when src1_val_i equals 32'hFFFF_FFFF, which is the value the compare instructions write for true. Any other value, including 0, 1 and 32'hFFFF_FFFE, leaves the sequence unchanged.
- R5: Opcode 20 on op_i is an unconditional branch and is always taken.
- R6: The target of a taken branch is the value on dst_val_i in the cycle the branch is accepted.
- R7: If a taken branch is accepted at edge t, pc_o steps by 1 at edge t (this is the slot instruction). At the next unstalled edge, pc_o loads the target. redirect_o is high for exactly the one cycle after that load.
- R8: When mode_i is 1 at acceptance, alu_susp_o and wb_susp_o are both high from the accepting edge until the load edge. When mode_i is 0, or the branch is not taken, both stay low.
- R9: A branch opcode seen while a redirect is pending (that is, in the slot position) is ignored: the target and the timing of the earlier branch apply.
- R10: A branch is accepted only when ex_valid_i is high and stall_i is low. Non-branch opcodes never redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freezes fetch address and pending redirect |
| mode_i | input | 1 | 0: exposed delay slot, 1: hardware suspend |
| ex_valid_i | input | 1 | Execute-stage instruction is valid |
| op_i | input | 8 | Opcode byte of execute-stage instruction |
| dst_val_i | input | 32 | Value of register named by dst field (target) |
| src1_val_i | input | 32 | Value of register named by src1 field (condition) |
| pc_o | output | 32 | Fetch address, in instruction words |
| redirect_o | output | 1 | One-cycle flag: pc_o now holds a branch target |
| alu_susp_o | output | 1 | Suspend ALU stage |
| wb_susp_o | output | 1 | Suspend register-write stage |

## Verification
pc_o and redirect_o are registered, so a branch accepted at edge t shows up as pc+1 after t and as the target with redirect_o after the following unstalled edge. The suspend outputs are decoded from registered state, so they are due in the cycle right after the accepting edge. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares all four outputs against that model on every falling edge, which keeps each check in the cycle its result is due.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned OP_W = 8;
  localparam logic [OP_W-1:0] OP_BR_TRUE   = 8'd19;
  localparam logic [OP_W-1:0] OP_BR_ALWAYS = 8'd20;

  typedef enum logic [1:0] {
    BR_NONE,
    BR_COND,
    BR_UNCOND
  } br_kind_e;
endpackage

// File: rtl/dbr_branch_eval.sv
module dbr_branch_eval
  import dbr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                ex_valid_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [XLEN-1:0]     dst_val_i,
  input  logic [XLEN-1:0]     src1_val_i,
  output logic                take_o,
  output logic [XLEN-1:0]     tgt_o
);
  localparam logic [XLEN-1:0] TRUE_VAL = '1;

  br_kind_e kind;

  always_comb begin
    kind = BR_NONE;
    if (ex_valid_i) begin
      unique case (op_i)
        OP_BR_TRUE:   kind = BR_COND;
        OP_BR_ALWAYS: kind = BR_UNCOND;
        default:      kind = BR_NONE;
      endcase
    end
  end

  always_comb begin
    unique case (kind)
      BR_COND:   take_o = (src1_val_i == TRUE_VAL);
      BR_UNCOND: take_o = 1'b1;
      default:   take_o = 1'b0;
    endcase
  end

  assign tgt_o = dst_val_i;

  always_comb begin
    if (!ex_valid_i) assert (!take_o) else $error("AST_NO_TAKE_INVALID"); // R10
  end
endmodule

// File: rtl/dbr_slot_ctrl.sv
module dbr_slot_ctrl #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            mode_i,
  input  logic            take_i,
  input  logic [XLEN-1:0] tgt_i,
  output logic            load_o,
  output logic [XLEN-1:0] tgt_o,
  output logic            alu_susp_o,
  output logic            wb_susp_o
);
  logic            pend_q;
  logic            hw_q;
  logic [XLEN-1:0] tgt_q;
  logic            accept;

  // no new capture while the slot is open
  assign accept = take_i && !stall_i && !pend_q;
  assign load_o = pend_q && !stall_i;
  assign tgt_o  = tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hw_q   <= 1'b0;
      tgt_q  <= '0;
    end else if (load_o) begin
      pend_q <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      hw_q   <= mode_i;
      tgt_q  <= tgt_i;
    end
  end

  logic susp;
  assign susp       = pend_q && hw_q;
  assign alu_susp_o = susp;
  assign wb_susp_o  = susp;

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && stall_i |=> pend_q && $stable(tgt_q)) else $error("AST_PEND_HOLD"); // R3
  AST_SLOT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !stall_i |=> !pend_q) else $error("AST_SLOT_IGNORED"); // R9
  AST_SUSP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alu_susp_o) |-> $past(take_i && mode_i && !stall_i)) else $error("AST_SUSP_CAUSE"); // R8
endmodule

// File: rtl/dbr_pc_reg.sv
module dbr_pc_reg #(
  parameter int unsigned XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            load_i,
  input  logic [XLEN-1:0] tgt_i,
  output logic [XLEN-1:0] pc_o,
  output logic            redirect_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o       <= RESET_PC;
      redirect_o <= 1'b0;
    end else begin
      redirect_o <= load_i;
      if (load_i)        pc_o <= tgt_i;
      else if (!stall_i) pc_o <= pc_o + STEP;
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i && !load_i |=> pc_o == $past(pc_o) + STEP) else $error("AST_SEQ_STEP"); // R2
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(pc_o)) else $error("AST_STALL_HOLD"); // R3
  AST_LOAD_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> redirect_o && pc_o == $past(tgt_i)) else $error("AST_LOAD_TARGET"); // R6
endmodule

// File: rtl/dbr_pc_seq.sv
module dbr_pc_seq
  import dbr_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            mode_i,
  input  logic            ex_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] dst_val_i,
  input  logic [XLEN-1:0] src1_val_i,
  output logic [XLEN-1:0] pc_o,
  output logic            redirect_o,
  output logic            alu_susp_o,
  output logic            wb_susp_o
);
  logic            take;
  logic [XLEN-1:0] br_tgt;
  logic            load;
  logic [XLEN-1:0] pend_tgt;

  dbr_branch_eval #(.XLEN(XLEN)) u_eval (
    .ex_valid_i (ex_valid_i),
    .op_i       (op_i),
    .dst_val_i  (dst_val_i),
    .src1_val_i (src1_val_i),
    .take_o     (take),
    .tgt_o      (br_tgt)
  );

  dbr_slot_ctrl #(.XLEN(XLEN)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .mode_i     (mode_i),
    .take_i     (take),
    .tgt_i      (br_tgt),
    .load_o     (load),
    .tgt_o      (pend_tgt),
    .alu_susp_o (alu_susp_o),
    .wb_susp_o  (wb_susp_o)
  );

  dbr_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .load_i     (load),
    .tgt_i      (pend_tgt),
    .pc_o       (pc_o),
    .redirect_o (redirect_o)
  );

  AST_REDIR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o) else $error("AST_REDIR_PULSE"); // R7
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !stall_i && !alu_susp_o && !load |=> pc_o == $past(pc_o) + XLEN'(1)) else $error("AST_SLOT_STEP"); // R7
endmodule

// File: tb/dbr_pc_seq_tb.sv
module dbr_pc_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        stall = 1'b0;
  logic        mode = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  op = 8'd0;
  logic [31:0] dstv = '0;
  logic [31:0] src1v = '0;
  logic [31:0] pc;
  logic        redir, asusp, wsusp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dbr_pc_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .mode_i(mode),
    .ex_valid_i(valid), .op_i(op), .dst_val_i(dstv), .src1_val_i(src1v),
    .pc_o(pc), .redirect_o(redir), .alu_susp_o(asusp), .wb_susp_o(wsusp)
  );

  // behavioural reference
  longint m_pc;
  bit     m_pend, m_hw, m_redir;
  longint m_tgt;

  function automatic bit taken_ref(bit v, logic [7:0] o, logic [31:0] s1);
    if (!v) return 0;
    if (o == 8'd20) return 1;
    if (o == 8'd19 && s1 == 32'hFFFF_FFFF) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_pend = 0; m_hw = 0; m_redir = 0; m_tgt = 0;
    end else if (m_pend && !stall) begin
      m_pc = m_tgt; m_pend = 0; m_redir = 1;
    end else begin
      m_redir = 0;
      if (!stall) begin
        if (!m_pend && taken_ref(valid, op, src1v)) begin
          m_pend = 1; m_tgt = dstv; m_hw = mode;
        end
        m_pc = (m_pc + 1) & 64'hFFFF_FFFF;
      end
    end
  end

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(pc == m_pc[31:0], "pc_o", pc, m_pc);
      chk(redir == m_redir, "redirect_o", redir, m_redir);
      chk(asusp == (m_pend && m_hw), "alu_susp_o", asusp, m_pend && m_hw);
      chk(wsusp == (m_pend && m_hw), "wb_susp_o", wsusp, m_pend && m_hw);
    end
  end

  task automatic step(bit v, logic [7:0] o, logic [31:0] d, logic [31:0] s, bit st, bit md);
    @(negedge clk);
    #1;
    valid = v; op = o; dstv = d; src1v = s; stall = st; mode = md;
  endtask

  task automatic idle(int n, bit md);
    for (int i = 0; i < n; i++) step(1, 8'd0, 32'h5, 32'h0, 0, md);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R2"; idle(5, 0);
    cur_req = "R5_R6_R7"; step(1, 8'd20, 32'h100, 32'h0, 0, 0); idle(4, 0);
    cur_req = "R4"; step(1, 8'd19, 32'h40, 32'hFFFF_FFFF, 0, 0); idle(3, 0);
    step(1, 8'd19, 32'h80, 32'h0, 0, 0); idle(2, 0);
    step(1, 8'd19, 32'h80, 32'hFFFF_FFFE, 0, 0); idle(2, 0);
    step(1, 8'd19, 32'h80, 32'h1, 0, 0); idle(2, 0);
    cur_req = "R9"; step(1, 8'd20, 32'h200, 32'h0, 0, 0);
    step(1, 8'd20, 32'h300, 32'h0, 0, 0); idle(3, 0);
    cur_req = "R3"; step(1, 8'd0, 32'h0, 32'h0, 1, 0); step(1, 8'd0, 32'h0, 32'h0, 1, 0); idle(1, 0);
    step(1, 8'd20, 32'h400, 32'h0, 0, 0);
    step(1, 8'd20, 32'h500, 32'h0, 1, 0); step(1, 8'd0, 32'h0, 32'h0, 1, 0); idle(3, 0);
    cur_req = "R8"; step(1, 8'd20, 32'h600, 32'h0, 0, 1); idle(3, 1);
    step(1, 8'd19, 32'h700, 32'hFFFF_FFFF, 0, 1);
    step(1, 8'd0, 32'h0, 32'h0, 1, 1); idle(3, 1);
    step(1, 8'd19, 32'h800, 32'h0, 0, 1); idle(3, 1);
    step(1, 8'd20, 32'h900, 32'h0, 0, 0); idle(3, 1);
    cur_req = "R10"; step(0, 8'd20, 32'hA00, 32'h0, 0, 0); idle(2, 0);
    step(1, 8'd21, 32'hB00, 32'hFFFF_FFFF, 0, 0); idle(2, 0);
    step(1, 8'd20, 32'hC00, 32'h0, 1, 0); idle(3, 0);
    cur_req = "R1";
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk); #1 rst_n = 1'b1;
    idle(2, 0);
    @(negedge clk);
    finish_run();
  end
endmodule